// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one core's data port and decides whether a store-conditional may reach memory. When the core issues a load-linked, the monitor passes the read through. It also remembers the address of that load and raises a reservation bit. The reservation survives only while nothing can have disturbed the line. A remote write to the same cache line drops it. So does a context-switch or translation-miss event. So does any other load or store the core issues before the store-conditional. The core's own store-conditional always consumes it, whether or not the store succeeds.

A store-conditional is forwarded to memory as a write only while the reservation is intact and the store targets the reserved cache line. The core receives a one-bit outcome one cycle later. For a bounded number of cycles after each load-linked, remote writes that hit the reserved line are held back. The monitor raises a stall toward the remote requester, and the held write is accepted once the window has run out. This guarantees that a short load-linked / store-conditional sequence can always complete. Line comparisons ignore the byte offset within a line, and the line size is a parameter.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no reservation exists: `rsp_valid`, `snp_stall` and `mem_we` are 0, and a store-conditional issued first fails without writing.
- R2: A load-linked (`op_kind` = 2) drives `mem_re` with `op_addr` in the same cycle. One cycle later it returns `mem_rdata` on `rsp_rdata` with `rsp_valid` high, and it establishes a reservation on that line.
- R3: A store-conditional (`op_kind` = 3) to the reserved line while the reservation holds drives `mem_we` with `op_addr` and `op_wdata` in the same cycle. One cycle later `rsp_sc_ok` is 1.
- R4: A failing store-conditional leaves `mem_we` at 0. One cycle later it responds with `rsp_valid` = 1 and `rsp_sc_ok` = 0.
- R5: An accepted remote write (`snp_valid` with `snp_stall` low) to the reserved line clears the reservation. This also applies in the cycle of a store-conditional, which then fails.
- R6: A remote write to a different line neither stalls nor affects the reservation.
- R7: A cycle with `ctx_evt` high clears the reservation.
- R8: An ordinary read (`op_kind` = 0) or write (`op_kind` = 1) issued by the core clears the reservation.
- R9: For HOLD_CYCLES cycles after the clock edge that records a load-linked, a remote write to the reserved line raises `snp_stall` and does not clear the reservation.
- R10: Addresses match at line granularity. Any byte offset within the same LINE_BYTES-aligned line matches, and the next line does not.
- R11: A store-conditional to a line other than the reserved one fails without writing and clears the reservation.
- R12: Every store-conditional, successful or not, consumes the reservation, so a second store-conditional fails.
- R13: Once the hold window expires, `snp_stall` falls for a pending remote write to the reserved line. That write is then accepted and clears the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core issues an operation this cycle |
| op_kind | input | 2 | 0 read, 1 write, 2 load-linked, 3 store-conditional |
| op_addr | input | ADDR_W | Byte address of the operation |
| op_wdata | input | DATA_W | Store data |
| ctx_evt | input | 1 | Context switch or translation miss |
| snp_valid | input | 1 | Remote write request observed |
| snp_addr | input | ADDR_W | Address of the remote write |
| snp_stall | output | 1 | Remote write refused this cycle; requester retries |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle as `mem_re` |
| rsp_valid | output | 1 | Response to the operation issued last cycle |
| rsp_sc_ok | output | 1 | Store-conditional outcome |
| rsp_rdata | output | DATA_W | Read data for a read or load-linked |

## Verification
The core path is exercised with several patterns:
- A load-linked followed directly by a store-conditional.
- A second store-conditional after one that succeeded.
- A store-conditional to a different offset in the same line, to the next line, and to an unrelated line.

These separate line-granular matching from full-address matching, and they show that every store-conditional consumes the reservation.

The reservation is attacked in turn by each of these, placed between the pair:
- a remote write to the same line after the hold window;
- a remote write to another line;
- a context event;
- an ordinary read;
- an ordinary write.

Each case shows which disturbance kills the link and which must not. A run of back-to-back remote writes to the reserved line starting right after the load-linked marks the exact cycle the stall ends. A store-conditional issued while such writes are still being stalled must succeed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_LL = 2'd2,
        OP_SC = 2'd3
    } op_kind_e;
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 6
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);
    localparam int TAG_W = ADDR_W - OFFS_W;

    logic [TAG_W-1:0] tag_a;
    logic [TAG_W-1:0] tag_b;

    assign tag_a     = addr_a[ADDR_W-1:OFFS_W];
    assign tag_b     = addr_b[ADDR_W-1:OFFS_W];
    assign same_line = (tag_a == tag_b);
endmodule

// File: rtl/llsc_hold_timer.sv
module llsc_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic drop,
    output logic active
);
    localparam int CNT_W = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (drop)
            cnt_d = '0;
        else if (load)
            cnt_d = CNT_W'(HOLD_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              ctx_evt,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_stall,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_sc_ok,
    output logic [DATA_W-1:0] rsp_rdata
);
    import llsc_pkg::*;

    localparam int OFFS_W = (LINE_BYTES < 2) ? 1 : $clog2(LINE_BYTES);

    typedef struct packed {
        logic              link_vld;
        logic [ADDR_W-1:0] link_addr;
        logic              rsp_valid;
        logic              rsp_sc_ok;
        logic [DATA_W-1:0] rsp_rdata;
    } mon_state_t;

    mon_state_t st_d, st_q;

    op_kind_e kind;
    logic     op_hit, snp_hit, hold_active;
    logic     snp_kill, flag_live, sc_ok, is_read;
    logic     timer_load, timer_drop;

    assign kind = op_kind_e'(op_kind);

    llsc_line_match #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_op_match (
        .addr_a    (op_addr),
        .addr_b    (st_q.link_addr),
        .same_line (op_hit)
    );

    llsc_line_match #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_snp_match (
        .addr_a    (snp_addr),
        .addr_b    (st_q.link_addr),
        .same_line (snp_hit)
    );

    llsc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .drop   (timer_drop),
        .active (hold_active)
    );

    always_comb begin
        st_d      = st_q;
        snp_stall = snp_valid & st_q.link_vld & snp_hit & hold_active;
        snp_kill  = snp_valid & st_q.link_vld & snp_hit & ~hold_active;
        flag_live = st_q.link_vld & ~snp_kill & ~ctx_evt;
        is_read   = op_valid & ((kind == OP_RD) | (kind == OP_LL));
        sc_ok     = op_valid & (kind == OP_SC) & flag_live & op_hit;

        mem_re    = is_read;
        mem_we    = op_valid & ((kind == OP_WR) | sc_ok);
        mem_addr  = op_addr;
        mem_wdata = op_wdata;

        st_d.link_vld = flag_live;
        if (op_valid) begin
            if (kind == OP_LL) begin
                st_d.link_vld  = 1'b1;
                st_d.link_addr = op_addr;
            end else begin
                st_d.link_vld = 1'b0;
            end
        end
        if (ctx_evt)
            st_d.link_vld = 1'b0;

        st_d.rsp_valid = op_valid;
        st_d.rsp_sc_ok = sc_ok;
        st_d.rsp_rdata = is_read ? mem_rdata : '0;

        timer_load = op_valid & (kind == OP_LL) & ~ctx_evt;
        timer_drop = ~st_d.link_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_sc_ok = st_q.rsp_sc_ok;
    assign rsp_rdata = st_q.rsp_rdata;
endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic       ctx_evt,
    input logic       snp_valid,
    input logic       snp_stall,
    input logic       mem_we,
    input logic       rsp_valid,
    input logic       rsp_sc_ok
);
    // R1
    rsp_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(op_valid));

    // R3
    sc_write_reports_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd3 && mem_we) |=> (rsp_valid && rsp_sc_ok));

    // R4
    sc_nowrite_reports_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd3 && !mem_we) |=> (rsp_valid && !rsp_sc_ok));

    // R9
    stall_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_stall |-> snp_valid);

    // R12
    sc_consumes_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd3) |=> !snp_stall);

    // R7
    ctx_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_evt && !(op_valid && op_kind == 2'd2)) |=> !snp_stall);
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .ctx_evt   (ctx_evt),
    .snp_valid (snp_valid),
    .snp_stall (snp_stall),
    .mem_we    (mem_we),
    .rsp_valid (rsp_valid),
    .rsp_sc_ok (rsp_sc_ok)
);

// File: tb/tb_llsc_resv_monitor.sv
module tb_llsc_resv_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int HOLD       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_kind = 2'd0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [DATA_W-1:0] op_wdata = '0;
    logic              ctx_evt = 1'b0;
    logic              snp_valid = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_stall, mem_re, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              rsp_valid, rsp_sc_ok;
    logic [DATA_W-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        exp_ok_q[$];
    logic        exp_rd_q[$];
    logic [31:0] exp_data_q[$];
    string       exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem_addr ^ 32'h5A5A_0F0F;

    llsc_resv_monitor #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_BYTES(LINE_BYTES), .HOLD_CYCLES(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .ctx_evt(ctx_evt),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_stall(snp_stall),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_sc_ok(rsp_sc_ok), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop scoreboard entries as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_ok_q.size() == 0) begin
                check("R1 unexpected response", 32'd1, 32'd0);
            end else begin
                logic        e_ok;
                logic        e_rd;
                logic [31:0] e_d;
                string       t;
                e_ok = exp_ok_q.pop_front();
                e_rd = exp_rd_q.pop_front();
                e_d  = exp_data_q.pop_front();
                t    = exp_tag_q.pop_front();
                check({t, " sc_ok"}, {31'd0, rsp_sc_ok}, {31'd0, e_ok});
                if (e_rd) check({t, " rdata"}, rsp_rdata, e_d);
            end
        end
    end

    // Driver: issue one operation, check its memory strobes, queue the response
    task automatic do_op(input logic [1:0] k, input logic [31:0] a,
                         input logic exp_we, input logic exp_ok, input string tag);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_addr = a; op_wdata = a + 32'h100;
        #1;
        check({tag, " mem_we"}, {31'd0, mem_we}, {31'd0, exp_we});
        if (k == 2'd2 || k == 2'd0)
            check({tag, " mem_re"}, {31'd0, mem_re}, 32'd1);
        if (exp_we) begin
            check({tag, " mem_addr"}, mem_addr, a);
            check({tag, " mem_wdata"}, mem_wdata, a + 32'h100);
        end
        exp_ok_q.push_back(exp_ok);
        exp_rd_q.push_back(k == 2'd2 || k == 2'd0);
        exp_data_q.push_back(a ^ 32'h5A5A_0F0F);
        exp_tag_q.push_back(tag);
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a, input logic exp_stall, input string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a;
        #1;
        check({tag, " snp_stall"}, {31'd0, snp_stall}, {31'd0, exp_stall});
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic ctx_pulse();
        @(negedge clk);
        ctx_evt = 1'b1;
        @(posedge clk); #1;
        ctx_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    localparam logic [31:0] A = 32'h0000_1040;
    localparam logic [31:0] B = 32'h0000_8000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 snp_stall in reset", {31'd0, snp_stall}, 32'd0);
        check("R1 mem_we in reset", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        do_op(2'd3, A, 1'b0, 1'b0, "R1 sc after reset");

        do_op(2'd2, A, 1'b0, 1'b0, "R2 ll");
        do_op(2'd3, A + 32'd4, 1'b1, 1'b1, "R3 R10 sc same line");
        do_op(2'd3, A, 1'b0, 1'b0, "R12 second sc");

        do_op(2'd2, A, 1'b0, 1'b0, "R5 ll");
        idle(HOLD);
        snoop(A + 32'd8, 1'b0, "R5 snoop after window");
        do_op(2'd3, A, 1'b0, 1'b0, "R5 sc after snoop");

        do_op(2'd2, A, 1'b0, 1'b0, "R6 ll");
        idle(HOLD);
        snoop(B, 1'b0, "R6 other-line snoop");
        do_op(2'd3, A, 1'b1, 1'b1, "R6 sc survives");

        do_op(2'd2, A, 1'b0, 1'b0, "R7 ll");
        ctx_pulse();
        do_op(2'd3, A, 1'b0, 1'b0, "R7 sc after ctx");

        do_op(2'd2, A, 1'b0, 1'b0, "R8 ll");
        do_op(2'd0, B, 1'b0, 1'b0, "R8 read between");
        do_op(2'd3, A, 1'b0, 1'b0, "R8 sc after read");
        do_op(2'd2, A, 1'b0, 1'b0, "R8 ll2");
        do_op(2'd1, B, 1'b1, 1'b0, "R8 write between");
        do_op(2'd3, A, 1'b0, 1'b0, "R8 sc after write");

        do_op(2'd2, A, 1'b0, 1'b0, "R9 ll");
        for (int i = 0; i < HOLD; i++) snoop(A, 1'b1, "R9 stalled snoop");
        snoop(A, 1'b0, "R13 snoop released");
        do_op(2'd3, A, 1'b0, 1'b0, "R13 sc after release");

        do_op(2'd2, A, 1'b0, 1'b0, "R9 ll short");
        for (int i = 0; i < 3; i++) snoop(A + 32'd16, 1'b1, "R9 stall short");
        do_op(2'd3, A, 1'b1, 1'b1, "R9 sc inside window");

        do_op(2'd2, A, 1'b0, 1'b0, "R11 ll");
        do_op(2'd3, B, 1'b0, 1'b0, "R11 sc other line");
        do_op(2'd3, A, 1'b0, 1'b0, "R11 link cleared");

        do_op(2'd2, A, 1'b0, 1'b0, "R10 ll");
        do_op(2'd3, A + LINE_BYTES, 1'b0, 1'b0, "R10 sc next line");

        idle(3);
        check("R4 scoreboard drained", exp_ok_q.size(), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule